// File: doc/BRIEF.md
# Three-Wire Enable-Framed Register Port

This block is a serial slave for a three-wire control link. The link is a serial clock, one bidirectional data line (brought to the block as a separate input, output and output-enable) and an active-low enable that frames each transfer. All three inputs are resynchronised into the block clock. Edges of the serial clock are then detected in that clock domain. There is no device address: the enable alone marks where a frame begins and ends.

The first byte after the enable falls is a subaddress. If it names a writable register, each later byte becomes a one-cycle pulse on the register write port. The address advances automatically after each byte and skips the gap between 07h and 0Bh. If the subaddress is one of the two read codes, the block snapshots the matching status input. It then drives that value out on the data line, one bit per falling serial clock edge.

Top module: `tw_regif`

## Requirements
- R1: While the enable (`sen_n`) is high, serial clock activity causes no register write and the data line is not driven.
- R2: Input bits are sampled on rising serial clock edges, MSB first. The first complete byte of a frame is the subaddress. When it is a writable address (00h to 07h, or 0Bh), the next data byte produces one single-cycle `wr_en` pulse with `wr_addr` equal to that subaddress.
- R3: Each further data byte is written to the next address. The sequence is 00h,01h..07h and then 0Bh.
- R4: Data bytes that arrive after the byte written to 0Bh are ignored.
- R5: Subaddress 82h makes the block shift out the 16-bit `stat_hi` value, MSB first. A new bit appears after each falling serial clock edge, and the first bit follows the first falling edge after the subaddress.
- R6: Subaddress 83h makes the block shift out the 8-bit `stat_lo` value, MSB first, with the same timing as R5.
- R7: `sdio_oe` is high only during the read phase of a frame. It falls no later than the second block clock edge after `sen_n` rises.
- R8: A partial byte pending when the enable rises is discarded and causes no write.
- R9: The status value is captured when the read subaddress completes. Changes on the status inputs during the read do not alter the bits shifted out.
- R10: Any other subaddress (08h to 0Ah, 0Ch to 81h, 84h to FFh) makes the rest of the frame ignored: no writes, and the line is not driven.
- R11: After reset, `wr_en` and `sdio_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the link master |
| sen_n | input | 1 | Active-low frame enable |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Data value driven during a read |
| sdio_oe | output | 1 | Pad output enable for the data line |
| wr_en | output | 1 | Register write strobe, one cycle per byte |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Register data of the write |
| stat_hi | input | 16 | Status word returned for subaddress 82h |
| stat_lo | input | 8 | Status byte returned for subaddress 83h |

## Verification
The hardest cases to reach are the ones where the frame boundary or the status inputs change in the middle of a byte. Examples are the enable rising after only a few bits of a data byte, and the status input changing after part of a word has already been shifted out. The bench drives the enable and the status inputs from its own serial tasks at chosen bit indices. A behavioural model, built from delay queues and integers, predicts the write port, output enable and data bit on every clock.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [1:0] {
    PH_SUB = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2,
    PH_IGN = 2'd3
  } phase_e;

  // Writable window: a contiguous low range plus one extra address.
  function automatic logic addr_writable(input logic [7:0] a,
                                         input logic [7:0] low_top,
                                         input logic [7:0] extra);
    return (a <= low_top) || (a == extra);
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic [W-1:0] d;
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      assign d = d_in;
    end else begin : g_rest
      assign d = g_st[s-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
    end
  end

  assign d_out = g_st[STAGES-1].q;

endmodule

// File: rtl/tw_rx.sv
module tw_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              sclk_fall,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_p_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              rise;

  assign rise      = sclk_s & ~sclk_p_q;
  assign sclk_fall = ~sclk_s & sclk_p_q;

  assign byte_val = {sh_q[BYTE_W-2:0], sdi_s};
  assign byte_vld = active & rise & (cnt_q == LAST_BIT);

  always_comb begin
    cnt_n = cnt_q;
    sh_n  = sh_q;
    if (!active) begin
      cnt_n = '0;
    end else if (rise) begin
      sh_n  = {sh_q[BYTE_W-2:0], sdi_s};
      cnt_n = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else begin
      sclk_p_q <= sclk_s;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
    end
  end

endmodule

// File: rtl/tw_seq.sv
module tw_seq
  import tw_pkg::*;
#(
  parameter int             BYTE_W    = 8,
  parameter int             HI_W      = 16,
  parameter int             LO_W      = 8,
  parameter logic [BYTE_W-1:0] SUB_RD_HI = 8'h82,
  parameter logic [BYTE_W-1:0] SUB_RD_LO = 8'h83,
  parameter logic [BYTE_W-1:0] LOW_TOP   = 8'h07,
  parameter logic [BYTE_W-1:0] EXTRA_REG = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [HI_W-1:0]   stat_hi,
  input  logic [LO_W-1:0]   stat_lo,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_load,
  output logic [HI_W-1:0]   rd_word
);

  localparam int PAD_W = HI_W - LO_W;

  phase_e            phase_q, phase_n;
  logic [BYTE_W-1:0] ptr_q, ptr_n;
  logic              wr_en_n;
  logic [BYTE_W-1:0] wr_addr_n, wr_data_n;

  always_comb begin
    phase_n   = phase_q;
    ptr_n     = ptr_q;
    wr_en_n   = 1'b0;
    wr_addr_n = wr_addr;
    wr_data_n = wr_data;
    rd_load   = 1'b0;
    rd_word   = '0;
    if (!active) begin
      phase_n = PH_SUB;
    end else if (byte_vld) begin
      case (phase_q)
        PH_SUB: begin
          if (byte_val == SUB_RD_HI) begin
            rd_load = 1'b1;
            rd_word = stat_hi;
            phase_n = PH_RD;
          end else if (byte_val == SUB_RD_LO) begin
            rd_load = 1'b1;
            rd_word = HI_W'(stat_lo) << PAD_W;
            phase_n = PH_RD;
          end else if (addr_writable(byte_val, LOW_TOP, EXTRA_REG)) begin
            ptr_n   = byte_val;
            phase_n = PH_WR;
          end else begin
            phase_n = PH_IGN;
          end
        end
        PH_WR: begin
          wr_en_n   = 1'b1;
          wr_addr_n = ptr_q;
          wr_data_n = byte_val;
          if (ptr_q == EXTRA_REG) begin
            phase_n = PH_IGN;
          end else if (ptr_q == LOW_TOP) begin
            ptr_n = EXTRA_REG;
          end else begin
            ptr_n = ptr_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SUB;
      ptr_q   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      phase_q <= phase_n;
      ptr_q   <= ptr_n;
      wr_en   <= wr_en_n;
      wr_addr <= wr_addr_n;
      wr_data <= wr_data_n;
    end
  end

endmodule

// File: rtl/tw_tx.sv
module tw_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         sclk_fall,
  output logic         sdo,
  output logic         oe
);

  logic [W-1:0] sh_q, sh_n;
  logic         armed_q, armed_n;
  logic         started_q, started_n;

  always_comb begin
    sh_n      = sh_q;
    armed_n   = armed_q;
    started_n = started_q;
    if (!active) begin
      armed_n   = 1'b0;
      started_n = 1'b0;
    end else if (load) begin
      sh_n      = load_word;
      armed_n   = 1'b1;
      started_n = 1'b0;
    end else if (sclk_fall && armed_q) begin
      if (!started_q) started_n = 1'b1;
      else            sh_n      = {sh_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      armed_q   <= 1'b0;
      started_q <= 1'b0;
    end else begin
      sh_q      <= sh_n;
      armed_q   <= armed_n;
      started_q <= started_n;
    end
  end

  assign sdo = sh_q[W-1];
  assign oe  = started_q & active;

endmodule

// File: rtl/tw_regif.sv
module tw_regif #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int HI_W        = 16,
  parameter int LO_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sen_n,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  input  logic [HI_W-1:0]   stat_hi,
  input  logic [LO_W-1:0]   stat_lo
);

  logic              rst_sync_n;
  logic [2:0]        pins_s;
  logic              sclk_s, sen_s, sdi_s;
  logic              active;
  logic              sclk_fall;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_val;
  logic              rd_load;
  logic [HI_W-1:0]   rd_word;

  tw_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_in(1'b1), .d_out(rst_sync_n)
  );

  tw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_pin_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_in({sclk, sen_n, sdio_in}), .d_out(pins_s)
  );

  assign {sclk_s, sen_s, sdi_s} = pins_s;
  assign active = ~sen_s;

  tw_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .active(active), .sclk_s(sclk_s),
    .sdi_s(sdi_s), .sclk_fall(sclk_fall), .byte_vld(byte_vld), .byte_val(byte_val)
  );

  tw_seq #(.BYTE_W(BYTE_W), .HI_W(HI_W), .LO_W(LO_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .active(active), .byte_vld(byte_vld),
    .byte_val(byte_val), .stat_hi(stat_hi), .stat_lo(stat_lo),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_load(rd_load), .rd_word(rd_word)
  );

  tw_tx #(.W(HI_W)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .active(active), .load(rd_load),
    .load_word(rd_word), .sclk_fall(sclk_fall), .sdo(sdio_out), .oe(sdio_oe)
  );

endmodule

// File: rtl/tw_regif_chk.sv
module tw_regif_chk #(
  parameter logic [7:0] LOW_TOP   = 8'h07,
  parameter logic [7:0] EXTRA_REG = 8'h0B
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sen_s,
  input logic       sclk_fall,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic       sdio_oe,
  input logic       sdio_out
);

  a_r1_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sen_s |=> !wr_en);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r3_legal_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= LOW_TOP || wr_addr == EXTRA_REG));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_s && $past(sen_s)) |-> !sdio_oe);

  a_r5_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && $past(sdio_oe) && !$past(sclk_fall)) |-> $stable(sdio_out));

endmodule

bind tw_regif tw_regif_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sen_s(sen_s), .sclk_fall(sclk_fall),
  .wr_en(wr_en), .wr_addr(wr_addr), .sdio_oe(sdio_oe), .sdio_out(sdio_out)
);

// File: tb/tw_regif_test.sv
`timescale 1ns/1ps
module tw_regif_test;

  logic        clk = 1'b0;
  logic        rst_n, sclk, sen_n, sdi_drv;
  logic        sdio_out, sdio_oe, wr_en;
  logic [7:0]  wr_addr, wr_data;
  logic [15:0] stat_hi;
  logic [7:0]  stat_lo;
  logic        line;

  always #2.5 clk = ~clk;
  assign line = sdio_oe ? sdio_out : sdi_drv;

  tw_regif uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n), .sdio_in(line),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stat_hi(stat_hi), .stat_lo(stat_lo)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit q_sclk[$], q_sen[$], q_sdi[$];
  int m_cnt, m_byte, m_ph, m_ptr, m_sh;
  bit m_arm, m_start, m_wr_en, exp_oe;
  int m_wa, m_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_sclk = '{0, 0, 0, 0}; q_sen = '{1, 1, 1, 1}; q_sdi = '{0, 0, 0, 0};
      m_cnt = 0; m_byte = 0; m_ph = 0; m_ptr = 0; m_sh = 0;
      m_arm = 0; m_start = 0; m_wr_en = 0; exp_oe = 0; m_wa = 0; m_wd = 0;
    end else begin
      bit s, p, act, d;
      q_sclk.push_front(sclk); q_sen.push_front(sen_n); q_sdi.push_front(line);
      void'(q_sclk.pop_back()); void'(q_sen.pop_back()); void'(q_sdi.pop_back());
      s = q_sclk[2]; p = q_sclk[3]; act = !q_sen[2]; d = q_sdi[2];
      m_wr_en = 0;
      if (!act) begin
        m_cnt = 0; m_ph = 0; m_arm = 0; m_start = 0;
      end else begin
        if (!s && p && m_arm) begin
          if (!m_start) m_start = 1;
          else m_sh = (m_sh << 1) & 16'hFFFF;
        end
        if (s && !p) begin
          m_byte = ((m_byte << 1) | d) & 8'hFF;
          m_cnt++;
          if (m_cnt == 8) begin
            m_cnt = 0;
            case (m_ph)
              0: begin
                if (m_byte == 8'h82) begin m_sh = stat_hi; m_arm = 1; m_start = 0; m_ph = 2; end
                else if (m_byte == 8'h83) begin m_sh = stat_lo << 8; m_arm = 1; m_start = 0; m_ph = 2; end
                else if (m_byte <= 7 || m_byte == 8'h0B) begin m_ptr = m_byte; m_ph = 1; end
                else m_ph = 3;
              end
              1: begin
                m_wr_en = 1; m_wa = m_ptr; m_wd = m_byte;
                if (m_ptr == 8'h0B) m_ph = 3;
                else if (m_ptr == 7) m_ptr = 8'h0B;
                else m_ptr++;
              end
              default: ;
            endcase
          end
        end
      end
      exp_oe = m_start && !q_sen[1];
    end
  end

  // per-clock comparison and write log
  int obs_a[$], obs_d[$];
  bit saw_oe;
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(wr_en === m_wr_en, "R2 wr_en vs model", wr_en, m_wr_en);
      if (m_wr_en) begin
        chk(wr_addr === 8'(m_wa), "R3 wr_addr vs model", wr_addr, m_wa);
        chk(wr_data === 8'(m_wd), "R2 wr_data vs model", wr_data, m_wd);
      end
      chk(sdio_oe === exp_oe, "R7 sdio_oe vs model", sdio_oe, exp_oe);
      if (exp_oe) chk(sdio_out === m_sh[15], "R5 sdio_out vs model", sdio_out, m_sh[15]);
    end
    if (wr_en) begin obs_a.push_back(wr_addr); obs_d.push_back(wr_data); end
    if (sdio_oe) saw_oe = 1;
  end

  // ---------------- serial master tasks ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    sdi_drv = b; wait_clk(4); sclk = 1; wait_clk(8); sclk = 0; wait_clk(4);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic read_bits(input int n, input int chg_at, input logic [15:0] chg_val,
                           output logic [15:0] val);
    val = '0;
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) stat_hi = chg_val;
      sdi_drv = 0; wait_clk(4); sclk = 1; wait_clk(4);
      val = {val[14:0], line};
      wait_clk(4); sclk = 0; wait_clk(4);
    end
  endtask

  task automatic start_frame();
    obs_a.delete(); obs_d.delete(); saw_oe = 0;
    sen_n = 0; wait_clk(8);
  endtask

  task automatic end_frame();
    sen_n = 1; wait_clk(3);
    chk(sdio_oe === 1'b0, "R7 released after enable high", sdio_oe, 0);
    wait_clk(12);
  endtask

  task automatic expect_write(input int idx, input int a, input int d, input string tag);
    if (idx < obs_a.size()) begin
      chk(obs_a[idx] == a, {tag, " addr"}, obs_a[idx], a);
      chk(obs_d[idx] == d, {tag, " data"}, obs_d[idx], d);
    end else chk(0, {tag, " missing write"}, obs_a.size(), idx + 1);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] rv;
    rst_n = 0; sclk = 0; sen_n = 1; sdi_drv = 0; stat_hi = 16'h0; stat_lo = 8'h0;
    wait_clk(6);
    rst_n = 1;
    wait_clk(6);
    cmp_on = 1;
    chk(wr_en === 1'b0, "R11 reset wr_en", wr_en, 0);
    chk(sdio_oe === 1'b0, "R11 reset sdio_oe", sdio_oe, 0);

    // R1: clocks with enable high do nothing
    obs_a.delete(); saw_oe = 0;
    send_byte(8'h82); send_byte(8'h03); send_byte(8'hAA);
    chk(obs_a.size() == 0, "R1 writes while idle", obs_a.size(), 0);
    chk(saw_oe == 0, "R1 drive while idle", saw_oe, 0);

    // R2/R3/R4: auto-increment across the gap and stop after 0Bh
    start_frame();
    send_byte(8'h05);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44); send_byte(8'h55);
    end_frame();
    expect_write(0, 8'h05, 8'h11, "R2 first write");
    expect_write(1, 8'h06, 8'h22, "R3 increment");
    expect_write(2, 8'h07, 8'h33, "R3 increment");
    expect_write(3, 8'h0B, 8'h44, "R3 skip to 0Bh");
    chk(obs_a.size() == 4, "R4 bytes past 0Bh ignored", obs_a.size(), 4);
    chk(saw_oe == 0, "R7 no drive in write frame", saw_oe, 0);

    // R2: single write at 00h
    start_frame();
    send_byte(8'h00); send_byte(8'hA5);
    end_frame();
    expect_write(0, 8'h00, 8'hA5, "R2 write at 00h");
    chk(obs_a.size() == 1, "R2 single write count", obs_a.size(), 1);

    // R8: partial trailing byte discarded
    start_frame();
    send_byte(8'h02); send_byte(8'h3C);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    end_frame();
    expect_write(0, 8'h02, 8'h3C, "R8 full byte kept");
    chk(obs_a.size() == 1, "R8 partial byte discarded", obs_a.size(), 1);

    // R8: a partial byte must not carry into the next frame
    start_frame();
    send_byte(8'h04); send_byte(8'h77);
    end_frame();
    expect_write(0, 8'h04, 8'h77, "R8 next frame aligned");

    // R10: unlisted subaddresses
    start_frame();
    send_byte(8'h09); send_byte(8'h12); send_byte(8'h34);
    end_frame();
    chk(obs_a.size() == 0, "R10 sub 09h no writes", obs_a.size(), 0);
    chk(saw_oe == 0, "R10 sub 09h no drive", saw_oe, 0);
    start_frame();
    send_byte(8'h84); send_byte(8'h12);
    end_frame();
    chk(obs_a.size() == 0, "R10 sub 84h no writes", obs_a.size(), 0);
    chk(saw_oe == 0, "R10 sub 84h no drive", saw_oe, 0);

    // R5: 16-bit read
    stat_hi = 16'hA5C3;
    start_frame();
    send_byte(8'h82);
    read_bits(16, -1, 16'h0, rv);
    chk(saw_oe == 1, "R7 drive during read", saw_oe, 1);
    end_frame();
    chk(rv == 16'hA5C3, "R5 16-bit read value", rv, 16'hA5C3);

    // R9: status change mid-read does not disturb the word
    stat_hi = 16'h1234;
    start_frame();
    send_byte(8'h82);
    read_bits(16, 4, 16'hFFFF, rv);
    end_frame();
    chk(rv == 16'h1234, "R9 captured at subaddress", rv, 16'h1234);

    // R6: 8-bit read
    stat_lo = 8'h9E;
    start_frame();
    send_byte(8'h83);
    read_bits(8, -1, 16'h0, rv);
    end_frame();
    chk(rv[7:0] == 8'h9E, "R6 8-bit read value", rv[7:0], 8'h9E);

    // R7: enable raised mid-read releases the line
    stat_hi = 16'hFFFF;
    start_frame();
    send_byte(8'h82);
    read_bits(3, -1, 16'h0, rv);
    chk(sdio_oe === 1'b1, "R7 driving mid-read", sdio_oe, 1);
    end_frame();
    chk(rv[2:0] == 3'b111, "R5 partial read bits", rv[2:0], 3'b111);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule